// File: doc/BRIEF.md
# Parallel 8-Point Multiplierless FFT

This block computes an 8-point complex discrete Fourier transform on a whole vector at once. It accepts eight complex samples on every clock and returns eight complex frequency bins on every clock. Each result appears a fixed number of cycles after its input. The datapath is a radix-2 decimation-in-frequency network with three butterfly stages. There are no general multipliers. The two irrational twiddle factors share one constant, close to 1/sqrt(2), and that constant is realised as a canonical signed digit sum of shifted copies. The quarter-turn twiddle is only a swap of the real and imaginary parts plus a negation.

Each butterfly stage halves its results with an arithmetic right shift. The output is therefore the DFT divided by 8. After the first rotation, an internal guard bit holds the growth that rotations can add to a single component. The final stage clamps each component to the 16-bit output range. Bins leave in natural order: the bit-reversal is done by fixed wiring.

Top module: `fft8_csd`

## Requirements
- R1: While rst_ni is low, and after reset until a qualified vector has had time to pass, valid_o is 0. Reset also clears every output component to 0.
- R2: valid_o is exactly valid_i delayed by 6 clock cycles. Idle gaps in valid_i appear at valid_o with the same spacing and the same length.
- R3: A new input vector can be accepted on every clock. Back-to-back vectors each give their own output vector, in the order they arrived.
- R4: Lane n of each input bus sits at bits [n*16 +: 16] (two's complement). Output lane k is X[k]/8, where X[k] = sum over n of x[n]*exp(-j*2*pi*k*n/8). Each component is within 4 LSB of this value.
- R5: Output lane 0 real part is within 2 LSB of the mean of the eight input real parts.
- R6: Output lane 4 real part is within 2 LSB of (x0 - x1 + x2 - x3 + x4 - x5 + x6 - x7)/8, taken over the input real parts.
- R7: The odd bins, which use the 1/sqrt(2) constant (realised as 0.70703), stay within 4 LSB of the ideal result for a single nonzero input sample.
- R8: A bin component whose ideal value lies outside [-32768, 32767] is clamped to the nearest limit. It does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector qualifier |
| x_re_i | input | 128 | Real parts of the 8 input samples, lane n at [n*16 +: 16] |
| x_im_i | input | 128 | Imaginary parts of the 8 input samples |
| valid_o | output | 1 | Output vector qualifier |
| y_re_o | output | 128 | Real parts of the 8 bins, bin k at [k*16 +: 16] |
| y_im_o | output | 128 | Imaginary parts of the 8 bins |

## Verification
A lane swap in the bit-reversal wiring moves energy into the wrong bin. A bad twiddle digit distorts only the odd bins. A single input impulse or tone exposes either fault within 6 cycles, on the first vector that reaches the output. A broken valid pipeline shows as an output qualifier that is early, late or missing against the inputs 6 cycles before. A missing guard bit or a wrapping clamp shows as a sign flip on a full-scale tone at the bin it drives.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  localparam int NPT   = 8;
  localparam int LAT   = 6;
  localparam int CFRAC = 8;
  // 0.70703 = 2^-1 + 2^-2 - 2^-4 + 2^-6 + 2^-8, bit i weights 2^-i
  localparam logic [CFRAC:0] CSD_POS = 9'b101000110;
  localparam logic [CFRAC:0] CSD_NEG = 9'b000010000;

  typedef enum logic [1:0] {ROT_PASS, ROT_W1, ROT_MJ, ROT_W3} rot_e;

  function automatic int bitrev3(input int k);
    return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
  endfunction
endpackage

// File: rtl/fft8_csd_scale.sv
module fft8_csd_scale #(
  parameter int W = 17,
  parameter int FRAC = 8,
  parameter logic [FRAC:0] POS_MASK = 9'b101000110,
  parameter logic [FRAC:0] NEG_MASK = 9'b000010000
) (
  input  logic signed [W:0]   v_i,
  output logic signed [W-1:0] p_o
);
  localparam int PW = W + FRAC + 2;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] v_ext;
  logic signed [PW-1:0] acc;

  assign v_ext = PW'(v_i);

  always_comb begin
    acc = RND;
    for (int i = 1; i <= FRAC; i++) begin
      if (POS_MASK[i]) acc = acc + (v_ext <<< (FRAC - i));
      if (NEG_MASK[i]) acc = acc - (v_ext <<< (FRAC - i));
    end
  end

  assign p_o = W'(acc >>> FRAC);
endmodule

// File: rtl/fft8_rot.sv
module fft8_rot
  import fft8_pkg::*;
#(
  parameter int W = 17,
  parameter rot_e ROT = ROT_PASS,
  parameter int FRAC = 8,
  parameter logic [FRAC:0] POS_MASK = 9'b101000110,
  parameter logic [FRAC:0] NEG_MASK = 9'b000010000
) (
  input  logic signed [W-1:0] a_re_i,
  input  logic signed [W-1:0] a_im_i,
  output logic signed [W-1:0] z_re_o,
  output logic signed [W-1:0] z_im_o
);
  generate
    if (ROT == ROT_PASS) begin : g_pass
      assign z_re_o = a_re_i;
      assign z_im_o = a_im_i;
    end else if (ROT == ROT_MJ) begin : g_mj
      assign z_re_o = a_im_i;
      assign z_im_o = -a_re_i;
    end else begin : g_diag
      logic signed [W:0]   sum_w, dif_w;
      logic signed [W-1:0] cs, cd;
      assign sum_w = (W+1)'(a_re_i) + (W+1)'(a_im_i);
      assign dif_w = (W+1)'(a_im_i) - (W+1)'(a_re_i);
      fft8_csd_scale #(.W(W), .FRAC(FRAC), .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK))
        i_sum (.v_i(sum_w), .p_o(cs));
      fft8_csd_scale #(.W(W), .FRAC(FRAC), .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK))
        i_dif (.v_i(dif_w), .p_o(cd));
      if (ROT == ROT_W1) begin : g_w1
        assign z_re_o = cs;
        assign z_im_o = cd;
      end else begin : g_w3
        assign z_re_o = cd;
        assign z_im_o = -cs;
      end
    end
  endgenerate
endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 17
) (
  input  logic signed [IN_W-1:0]  a_re_i,
  input  logic signed [IN_W-1:0]  a_im_i,
  input  logic signed [IN_W-1:0]  b_re_i,
  input  logic signed [IN_W-1:0]  b_im_i,
  output logic signed [OUT_W-1:0] s_re_o,
  output logic signed [OUT_W-1:0] s_im_o,
  output logic signed [OUT_W-1:0] d_re_o,
  output logic signed [OUT_W-1:0] d_im_o
);
  function automatic logic signed [OUT_W-1:0] half(input logic signed [IN_W:0] t);
    logic signed [IN_W:0] h;
    h = t >>> 1;
    return OUT_W'(h);
  endfunction

  assign s_re_o = half((IN_W+1)'(a_re_i) + (IN_W+1)'(b_re_i));
  assign s_im_o = half((IN_W+1)'(a_im_i) + (IN_W+1)'(b_im_i));
  assign d_re_o = half((IN_W+1)'(a_re_i) - (IN_W+1)'(b_re_i));
  assign d_im_o = half((IN_W+1)'(a_im_i) - (IN_W+1)'(b_im_i));
endmodule

// File: rtl/fft8_csd.sv
module fft8_csd
  import fft8_pkg::*;
#(
  parameter int DW = 16,
  parameter int FRAC = CFRAC,
  parameter logic [FRAC:0] POS_MASK = CSD_POS,
  parameter logic [FRAC:0] NEG_MASK = CSD_NEG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [NPT*DW-1:0] x_re_i,
  input  logic [NPT*DW-1:0] x_im_i,
  output logic              valid_o,
  output logic [NPT*DW-1:0] y_re_o,
  output logic [NPT*DW-1:0] y_im_o
);
  localparam int IW = DW + 1;
  localparam int H  = NPT / 2;
  localparam logic signed [IW-1:0] HI = IW'((2 ** (DW - 1)) - 1);
  localparam logic signed [IW-1:0] LO = -HI - IW'(1);

  function automatic logic signed [DW-1:0] sat(input logic signed [IW-1:0] v);
    if (v > HI) return DW'(HI);
    if (v < LO) return DW'(LO);
    return DW'(v);
  endfunction

  logic [LAT-1:0] vld_q;
  logic signed [DW-1:0] x_re_q [NPT], x_im_q [NPT];
  logic signed [IW-1:0] bf1_re [NPT], bf1_im [NPT], s2_re [NPT], s2_im [NPT];
  logic signed [IW-1:0] rt1_re [NPT], rt1_im [NPT], s3_re [NPT], s3_im [NPT];
  logic signed [IW-1:0] bf2_re [NPT], bf2_im [NPT], s4_re [NPT], s4_im [NPT];
  logic signed [IW-1:0] rt2_re [NPT], rt2_im [NPT], s5_re [NPT], s5_im [NPT];
  logic signed [IW-1:0] bf3_re [NPT], bf3_im [NPT];
  logic signed [DW-1:0] y_re_q [NPT], y_im_q [NPT];

  // stage 1: span-4 butterflies
  for (genvar n = 0; n < H; n++) begin : g_st1
    fft8_bfly #(.IN_W(DW), .OUT_W(IW)) i_bf (
      .a_re_i(x_re_q[n]), .a_im_i(x_im_q[n]),
      .b_re_i(x_re_q[n+H]), .b_im_i(x_im_q[n+H]),
      .s_re_o(bf1_re[n]), .s_im_o(bf1_im[n]),
      .d_re_o(bf1_re[n+H]), .d_im_o(bf1_im[n+H]));
  end

  // rotation 1: W8^n on the difference half
  for (genvar n = 0; n < NPT; n++) begin : g_rt1
    if (n < H) begin : g_thru
      assign rt1_re[n] = s2_re[n];
      assign rt1_im[n] = s2_im[n];
    end else begin : g_tw
      fft8_rot #(.W(IW), .ROT(rot_e'(n - H)), .FRAC(FRAC),
                 .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK)) i_rot (
        .a_re_i(s2_re[n]), .a_im_i(s2_im[n]),
        .z_re_o(rt1_re[n]), .z_im_o(rt1_im[n]));
    end
  end

  // stage 2: span-2 butterflies inside each half
  for (genvar g = 0; g < 2; g++) begin : g_st2
    for (genvar m = 0; m < 2; m++) begin : g_m
      fft8_bfly #(.IN_W(IW), .OUT_W(IW)) i_bf (
        .a_re_i(s3_re[4*g+m]), .a_im_i(s3_im[4*g+m]),
        .b_re_i(s3_re[4*g+m+2]), .b_im_i(s3_im[4*g+m+2]),
        .s_re_o(bf2_re[4*g+m]), .s_im_o(bf2_im[4*g+m]),
        .d_re_o(bf2_re[4*g+m+2]), .d_im_o(bf2_im[4*g+m+2]));
    end
  end

  // rotation 2: -j on the odd difference of each half
  for (genvar n = 0; n < NPT; n++) begin : g_rt2
    if ((n % 4) == 3) begin : g_mj
      fft8_rot #(.W(IW), .ROT(ROT_MJ), .FRAC(FRAC),
                 .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK)) i_rot (
        .a_re_i(s4_re[n]), .a_im_i(s4_im[n]),
        .z_re_o(rt2_re[n]), .z_im_o(rt2_im[n]));
    end else begin : g_thru
      assign rt2_re[n] = s4_re[n];
      assign rt2_im[n] = s4_im[n];
    end
  end

  // stage 3: adjacent pairs
  for (genvar p = 0; p < H; p++) begin : g_st3
    fft8_bfly #(.IN_W(IW), .OUT_W(IW)) i_bf (
      .a_re_i(s5_re[2*p]), .a_im_i(s5_im[2*p]),
      .b_re_i(s5_re[2*p+1]), .b_im_i(s5_im[2*p+1]),
      .s_re_o(bf3_re[2*p]), .s_im_o(bf3_im[2*p]),
      .d_re_o(bf3_re[2*p+1]), .d_im_o(bf3_im[2*p+1]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int n = 0; n < NPT; n++) begin
        x_re_q[n] <= '0; x_im_q[n] <= '0;
        s2_re[n]  <= '0; s2_im[n]  <= '0;
        s3_re[n]  <= '0; s3_im[n]  <= '0;
        s4_re[n]  <= '0; s4_im[n]  <= '0;
        s5_re[n]  <= '0; s5_im[n]  <= '0;
        y_re_q[n] <= '0; y_im_q[n] <= '0;
      end
    end else begin
      vld_q <= {vld_q[LAT-2:0], valid_i};
      for (int n = 0; n < NPT; n++) begin
        x_re_q[n] <= x_re_i[n*DW +: DW];
        x_im_q[n] <= x_im_i[n*DW +: DW];
        s2_re[n]  <= bf1_re[n]; s2_im[n] <= bf1_im[n];
        s3_re[n]  <= rt1_re[n]; s3_im[n] <= rt1_im[n];
        s4_re[n]  <= bf2_re[n]; s4_im[n] <= bf2_im[n];
        s5_re[n]  <= rt2_re[n]; s5_im[n] <= rt2_im[n];
        // natural order by wiring
        y_re_q[n] <= sat(bf3_re[bitrev3(n)]);
        y_im_q[n] <= sat(bf3_im[bitrev3(n)]);
      end
    end
  end

  assign valid_o = vld_q[LAT-1];
  for (genvar k = 0; k < NPT; k++) begin : g_out
    assign y_re_o[k*DW +: DW] = y_re_q[k];
    assign y_im_o[k*DW +: DW] = y_im_q[k];
  end

  // ---------------- assertions ----------------
  localparam int CW = DW + 5;
  localparam int SH = $clog2(NPT);
  localparam logic signed [CW-1:0] ETOL = CW'(2 * NPT);

  logic [2:0] warm_q;
  logic signed [CW-1:0] dc_in, ny_in, dc_err, ny_err;
  logic signed [CW-1:0] dc_h [LAT], ny_h [LAT];

  always_comb begin
    dc_in = '0;
    ny_in = '0;
    for (int n = 0; n < NPT; n++) begin
      dc_in = dc_in + CW'(signed'(x_re_i[n*DW +: DW]));
      if (n % 2 == 0) ny_in = ny_in + CW'(signed'(x_re_i[n*DW +: DW]));
      else            ny_in = ny_in - CW'(signed'(x_re_i[n*DW +: DW]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      for (int i = 0; i < LAT; i++) begin dc_h[i] <= '0; ny_h[i] <= '0; end
    end else begin
      if (warm_q < 3'(LAT)) warm_q <= warm_q + 3'd1;
      dc_h[0] <= dc_in;
      ny_h[0] <= ny_in;
      for (int i = 1; i < LAT; i++) begin dc_h[i] <= dc_h[i-1]; ny_h[i] <= ny_h[i-1]; end
    end
  end

  assign dc_err = (CW'(signed'(y_re_o[0 +: DW])) <<< SH) - dc_h[LAT-1];
  assign ny_err = (CW'(signed'(y_re_o[4*DW +: DW])) <<< SH) - ny_h[LAT-1];

  assert_quiet_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q < 3'(LAT)) |-> !valid_o);
  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 3'(LAT)) |-> (valid_o == $past(valid_i, 6)));
  assert_dc_bin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((dc_err >= -ETOL) && (dc_err <= ETOL)));
  assert_nyquist_bin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((ny_err >= -ETOL) && (ny_err <= ETOL)));
endmodule

// File: tb/test_fft8_csd.sv
`timescale 1ns/1ps
module test_fft8_csd;
  localparam int DW = 16, NPT = 8, LAT = 6;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_n = 1'b0, valid_i = 1'b0;
  logic [NPT*DW-1:0] x_re = '0, x_im = '0;
  logic valid_o;
  logic [NPT*DW-1:0] y_re, y_im;

  fft8_csd i_fft8_csd (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .x_re_i(x_re), .x_im_i(x_im), .valid_o(valid_o), .y_re_o(y_re), .y_im_o(y_im));

  always #4 clk = ~clk;

  int cyc = 0, errors = 0, checks = 0;
  int due_q[$], tol_q[$];
  string req_q[$];
  real er_q[$], ei_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real clampr(input real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  task automatic send(input int re[NPT], input int im[NPT], input int tol, input string req);
    @(negedge clk);
    for (int n = 0; n < NPT; n++) begin
      x_re[n*DW +: DW] = DW'(re[n]);
      x_im[n*DW +: DW] = DW'(im[n]);
    end
    valid_i = 1'b1;
    due_q.push_back(cyc + LAT);
    tol_q.push_back(tol);
    req_q.push_back(req);
    for (int k = 0; k < NPT; k++) begin
      real sr = 0.0, si = 0.0;
      for (int n = 0; n < NPT; n++) begin
        real a = 2.0 * PI * k * n / NPT;
        sr += re[n] * $cos(a) + im[n] * $sin(a);
        si += im[n] * $cos(a) - re[n] * $sin(a);
      end
      er_q.push_back(clampr(sr / NPT));
      ei_q.push_back(clampr(si / NPT));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
      for (int i = 0; i < NPT; i++) begin
        x_re[i*DW +: DW] = DW'($urandom);
        x_im[i*DW +: DW] = DW'($urandom);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        checks++;
        if (due_q.size() == 0) begin
          errors++;
          $display("FAIL R2: valid_o=1 at cycle %0d, expected no output", cyc);
        end else begin
          int d, tol, bad;
          string req;
          real ar, ai, xr, xi, wr, wi;
          d = due_q.pop_front(); tol = tol_q.pop_front(); req = req_q.pop_front();
          if (d != cyc) begin
            errors++;
            $display("FAIL R2: output at cycle %0d, expected cycle %0d", cyc, d);
          end
          checks++;
          bad = -1;
          for (int k = 0; k < NPT; k++) begin
            real er, ei;
            er = er_q.pop_front(); ei = ei_q.pop_front();
            ar = $itor($signed(y_re[k*DW +: DW]));
            ai = $itor($signed(y_im[k*DW +: DW]));
            if (bad < 0 && ((ar - er > tol) || (er - ar > tol) || (ai - ei > tol) || (ei - ai > tol))) begin
              bad = k; wr = ar; wi = ai; xr = er; xi = ei;
            end
          end
          if (bad >= 0) begin
            errors++;
            $display("FAIL %s: bin %0d actual=(%0.1f,%0.1f) expected=(%0.2f,%0.2f)",
                     req, bad, wr, wi, xr, xi);
          end
        end
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        errors++; checks++;
        $display("FAIL R2: valid_o=0 at cycle %0d, expected 1", cyc);
        void'(due_q.pop_front()); void'(tol_q.pop_front()); void'(req_q.pop_front());
        for (int k = 0; k < NPT; k++) begin void'(er_q.pop_front()); void'(ei_q.pop_front()); end
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2: watchdog expired, actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int re[NPT], im[NPT];
    repeat (5) @(negedge clk);
    // R1: reset state
    checks++;
    if (valid_o !== 1'b0 || y_re !== '0 || y_im !== '0) begin
      errors++;
      $display("FAIL R1: in reset valid_o=%b y_re=%h, expected 0", valid_o, y_re);
    end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if (valid_o !== 1'b0 || y_re !== '0) begin
      errors++;
      $display("FAIL R1: after reset valid_o=%b, expected 0", valid_o);
    end

    // R5: DC vectors
    foreach (re[n]) begin re[n] = 1234; im[n] = -567; end
    send(re, im, 2, "R5");
    foreach (re[n]) begin re[n] = -32768; im[n] = -32768; end
    send(re, im, 2, "R5");
    foreach (re[n]) begin re[n] = 32767; im[n] = 100; end
    send(re, im, 2, "R5");
    // R6: alternating
    foreach (re[n]) begin re[n] = (n % 2) ? -20000 : 20000; im[n] = (n % 2) ? 7 : -7; end
    send(re, im, 2, "R6");
    foreach (re[n]) begin re[n] = (n % 2) ? -32768 : 32767; im[n] = 0; end
    send(re, im, 2, "R6");
    // R7: single impulses at odd positions
    foreach (re[n]) begin re[n] = 0; im[n] = 0; end
    re[1] = 20000; im[1] = -12000;
    send(re, im, 4, "R7");
    foreach (re[n]) begin re[n] = 0; im[n] = 0; end
    re[3] = -25000; im[3] = 9000;
    send(re, im, 4, "R7");
    foreach (re[n]) begin re[n] = 0; im[n] = 0; end
    re[5] = 32767; im[5] = 32767;
    send(re, im, 4, "R7");
    // R8: full-scale tone driving bin 1 beyond range
    re = '{32767, 32767, 32767, -32767, -32767, -32767, -32767, 32767};
    im = '{32767, 32767, 32767, 32767, 32767, -32767, -32767, -32767};
    send(re, im, 4, "R8");
    re = '{-32767, -32767, -32767, 32767, 32767, 32767, 32767, -32767};
    im = '{-32767, -32767, -32767, -32767, -32767, 32767, 32767, 32767};
    send(re, im, 4, "R8");
    // R2: gaps of differing length
    idle(3);
    foreach (re[n]) begin re[n] = 100 * n - 300; im[n] = 50 - 20 * n; end
    send(re, im, 4, "R2");
    idle(1);
    send(re, im, 4, "R2");
    idle(5);
    // R3 R4: back-to-back random vectors
    for (int v = 0; v < 300; v++) begin
      foreach (re[n]) begin
        re[n] = int'($urandom_range(65535)) - 32768;
        im[n] = int'($urandom_range(65535)) - 32768;
      end
      send(re, im, 4, "R3 R4");
    end
    idle(LAT + 4);
    checks++;
    if (due_q.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d vectors without output, expected 0", due_q.size());
    end
    summary();
    $finish;
  end
endmodule